// File: doc/BRIEF.md
# Timer Channel with Shadow-Buffered Compare and Capture Registers

This block is the register side of one timer channel. It holds four 16-bit general registers, named A, B, C and D, which are all compared against an external free-running count. Register A and register C can also latch the count when an edge arrives on a capture pin. Registers B and D are compare-only.

Each register pair can be linked by its own enable: C with A, and D with B. When a pair is linked, the upper register of the pair works as a shadow of the lower one. If the lower register captures, the value it held moves into the shadow on the same edge, so two captures are kept. If the lower register compares, software writes only the shadow. The lower register then reloads from the shadow on the cycle after each match, so a new period or duty value takes effect only at a match boundary.

Software reaches all four registers through a single write port and a registered read port. The block reports a registered match flag for each register.

Top module: `cbr_channel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all four registers read as 0 and `cmp_hit` is 0.
- R2: A write with `wr_en` high stores `wr_data` into the register selected by `wr_sel` (0=A, 1=B, 2=C, 3=D), unless a rule below blocks the write. `rd_data` shows the register selected by `rd_sel`, as it was at the previous clock edge.
- R3: A register in compare behaviour that equals `cnt` at a clock edge raises its bit of `cmp_hit` (bit 0=A, 1=B, 2=C, 3=D) for the following cycle.
- R4: A or C with its `mode_cap` bit set (bit index = register index) loads `cnt` on a qualifying capture-pin edge. While in capture behaviour the register raises no match flag.
- R5: `cap_edge` selects the qualifying edge of `cap_in`: 0 none, 1 rising, 2 falling, 3 both. An edge is seen at the clock edge where `cap_in` differs from its value one cycle earlier.
- R6: When `buf_en[0]` is set and A captures, C takes the value A held before, on the same clock edge that A takes `cnt`.
- R7: When `buf_en[0]` is set and A compares, A loads the value of C on the clock edge after the match edge, and C raises no match flag of its own.
- R8: When a pair is linked and its lower register compares, a write to the lower register is ignored, and a write to the upper (shadow) register is accepted.
- R9: `buf_en[0]` links only A/C and `buf_en[1]` links only B/D. An unlinked pair works as two plain registers. A linked B/D pair reloads B from D on the edge after a B match.
- R10: Setting `mode_cap` bit 1 or 3 has no effect: B and D keep their values on capture edges and go on comparing.
- R11: When a capture and a write target the same register on the same edge, the captured count is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | 16 | Counter value to compare against and capture |
| cap_in | input | 1 | Capture pin |
| cap_edge | input | 2 | Capture edge select (0 none, 1 rise, 2 fall, 3 both) |
| mode_cap | input | 4 | Per-register capture request, one bit per register A..D |
| buf_en | input | 2 | Pair link enables: bit 0 A/C, bit 1 B/D |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Registered read data |
| cmp_hit | output | 4 | Registered match flags, one per register |

## Verification
The assertions check these rules on every cycle:
- In a linked capture, the old value moves to the shadow while the count enters the lower register.
- In a linked compare, the lower register reloads from the shadow on the cycle after a match and holds its value at all other times.
- A register in capture behaviour raises no match flag.
- B and D change only through writes or a reload.

The bench scenarios are needed for the following:
- Edge selection.
- The exact cycle at which a reload becomes visible on the read port.
- Capture winning over a same-cycle write.
- The independence of the two pair enables.
- A long random mix of mode changes checked against a reference model.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/cbr_edge.sv
module cbr_edge (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pin,
  input  cbr_pkg::edge_mode_e   mode,
  output logic                  evt
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin;
  end

  assign rise = pin & ~prev_q;
  assign fall = ~pin & prev_q;

  always_comb begin
    case (mode)
      cbr_pkg::EDGE_RISE: evt = rise;
      cbr_pkg::EDGE_FALL: evt = fall;
      cbr_pkg::EDGE_BOTH: evt = rise | fall;
      default:            evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_pair.sv
module cbr_pair #(
  parameter int DW     = 16,
  parameter bit CAP_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cnt,
  input  logic          cap_evt,
  input  logic          buf_en,
  input  logic          capreq_p,
  input  logic          capreq_s,
  input  logic          wr_p,
  input  logic          wr_s,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] p_q,
  output logic [DW-1:0] s_q,
  output logic          hit_p_q,
  output logic          hit_s_q
);
  logic cap_p, cap_s, bcmp, pcap, scap, xfer;

  assign cap_p = capreq_p & CAP_OK;
  assign cap_s = capreq_s & CAP_OK & ~buf_en;
  assign bcmp  = buf_en & ~cap_p;
  assign pcap  = cap_p & cap_evt;
  assign scap  = cap_s & cap_evt;
  assign xfer  = bcmp & hit_p_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q     <= '0;
      s_q     <= '0;
      hit_p_q <= 1'b0;
      hit_s_q <= 1'b0;
    end else begin
      if (pcap)              p_q <= cnt;
      else if (xfer)         p_q <= s_q;
      else if (wr_p && !bcmp) p_q <= wdata;

      if (pcap && buf_en)    s_q <= p_q;
      else if (scap)         s_q <= cnt;
      else if (wr_s)         s_q <= wdata;

      hit_p_q <= ~cap_p & (cnt == p_q);
      hit_s_q <= ~buf_en & ~cap_s & (cnt == s_q);
    end
  end

  // R6
  cap_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (pcap && buf_en) |=> (s_q == $past(p_q)) && (p_q == $past(cnt)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (bcmp && hit_p_q) |=> (p_q == $past(s_q)));

  // R8
  prim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bcmp && !hit_p_q) |=> $stable(p_q));

  // R4
  cap_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    hit_p_q |-> $past(!cap_p));

  if (!CAP_OK) begin : g_nocap
    // R10
    nocap_prim_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_p && !(buf_en && hit_p_q)) |=> $stable(p_q));
    // R10
    nocap_sec_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_s |=> $stable(s_q));
  end
endmodule

// File: rtl/cbr_rdmux.sv
module cbr_rdmux #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] vals [NREG],
  output logic [DW-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= vals[sel];
  end
endmodule

// File: rtl/cbr_channel.sv
module cbr_channel #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cnt,
  input  logic          cap_in,
  input  logic [1:0]    cap_edge,
  input  logic [3:0]    mode_cap,
  input  logic [1:0]    buf_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [3:0]    cmp_hit
);
  localparam int NPAIR = 2;
  localparam int NREG  = 2 * NPAIR;

  logic          cap_evt;
  logic [DW-1:0] regs [NREG];

  cbr_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .pin  (cap_in),
    .mode (cbr_pkg::edge_mode_e'(cap_edge)),
    .evt  (cap_evt)
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    cbr_pair #(.DW(DW), .CAP_OK(g == 0)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt),
      .cap_evt  (cap_evt),
      .buf_en   (buf_en[g]),
      .capreq_p (mode_cap[g]),
      .capreq_s (mode_cap[g+NPAIR]),
      .wr_p     (wr_en && (wr_sel == 2'(g))),
      .wr_s     (wr_en && (wr_sel == 2'(g + NPAIR))),
      .wdata    (wr_data),
      .p_q      (regs[g]),
      .s_q      (regs[g+NPAIR]),
      .hit_p_q  (cmp_hit[g]),
      .hit_s_q  (cmp_hit[g+NPAIR])
    );
  end

  cbr_rdmux #(.DW(DW), .NREG(NREG)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .sel  (rd_sel),
    .vals (regs),
    .rd_q (rd_data)
  );
endmodule

// File: tb/cbr_channel_tb.sv
module cbr_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cnt;
  logic        cap_in;
  logic [1:0]  cap_edge;
  logic [3:0]  mode_cap;
  logic [1:0]  buf_en;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic [3:0]  cmp_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_r [4];
  logic [3:0]  m_hit;
  logic        m_prev;
  logic [15:0] m_rd;

  always #10 clk = ~clk;

  cbr_channel dut_i (
    .clk(clk), .rst(rst), .cnt(cnt), .cap_in(cap_in), .cap_edge(cap_edge),
    .mode_cap(mode_cap), .buf_en(buf_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cmp_hit(cmp_hit)
  );

  function automatic logic edge_seen(logic pin, logic prev, logic [1:0] m);
    logic rise = pin & ~prev;
    logic fall = ~pin & prev;
    return (m[0] & rise) | (m[1] & fall);
  endfunction

  task automatic tick();
    logic [15:0] nr [4];
    logic [3:0]  nh;
    logic        evt;
    evt = edge_seen(cap_in, m_prev, cap_edge);
    for (int i = 0; i < 4; i++) nr[i] = m_r[i];
    nh = '0;
    for (int p = 0; p < 2; p++) begin
      logic ok, cp, cs, bc, bf;
      ok = (p == 0);
      bf = buf_en[p];
      cp = ok & mode_cap[p];
      cs = ok & mode_cap[p+2] & ~bf;
      bc = bf & ~cp;
      if (cp && evt) nr[p] = cnt;
      else if (bc && m_hit[p]) nr[p] = m_r[p+2];
      else if (wr_en && wr_sel == 2'(p) && !bc) nr[p] = wr_data;
      if (cp && evt && bf) nr[p+2] = m_r[p];
      else if (cs && evt) nr[p+2] = cnt;
      else if (wr_en && wr_sel == 2'(p+2)) nr[p+2] = wr_data;
      nh[p]   = ~cp & (cnt == m_r[p]);
      nh[p+2] = ~bf & ~cs & (cnt == m_r[p+2]);
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) m_r[i] = '0;
      m_hit = '0; m_prev = 1'b0; m_rd = '0;
    end else begin
      m_rd = m_r[rd_sel];
      for (int i = 0; i < 4; i++) m_r[i] = nr[i];
      m_hit = nh; m_prev = cap_in;
    end
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [1:0] sel, output logic [15:0] v);
    rd_sel = sel;
    tick();
    v = rd_data;
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic cap_pulse(logic [15:0] c);
    cnt = c; cap_in = 1'b1; tick();
    cnt = 16'hFFFF; cap_in = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst = 1'b1; cnt = 16'hFFFF; cap_in = 0; cap_edge = 0; mode_cap = 0;
    buf_en = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    m_hit = '0; m_prev = 0; m_rd = '0;
    @(negedge clk);
    repeat (3) tick();
    chk("R1 hit in reset", {12'd0, cmp_hit}, 16'd0);
    chk("R1 rd in reset", rd_data, 16'd0);
    rst = 1'b0;
    tick();
    chk("R1 hit after reset", {12'd0, cmp_hit}, 16'd0);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 reg zero", v, 16'd0);
    end

    // R2 write and read back
    wr(0, 16'h1234); wr(1, 16'h5678); wr(2, 16'h9ABC); wr(3, 16'hDEF0);
    rd(0, v); chk("R2 A", v, 16'h1234);
    rd(1, v); chk("R2 B", v, 16'h5678);
    rd(2, v); chk("R2 C", v, 16'h9ABC);
    rd(3, v); chk("R2 D", v, 16'hDEF0);

    // R3 compare match flag
    cnt = 16'h1234; tick();
    chk("R3 A hit", {12'd0, cmp_hit}, 16'h0001);
    cnt = 16'hFFFF; tick();
    chk("R3 hit clears", {12'd0, cmp_hit}, 16'h0000);

    // R4 / R5 capture with edge select
    mode_cap = 4'b0001; cap_edge = 2'd1;
    cnt = 16'h0055; cap_in = 1; tick();
    chk("R4 no hit in capture", {12'd0, cmp_hit}, 16'h0000);
    cnt = 16'h0066; cap_in = 0; tick();
    cnt = 16'hFFFF;
    rd(0, v); chk("R5 rising only", v, 16'h0055);
    cap_edge = 2'd2;
    cnt = 16'h0077; cap_in = 1; tick();
    cnt = 16'h0088; cap_in = 0; tick();
    cnt = 16'hFFFF;
    rd(0, v); chk("R5 falling only", v, 16'h0088);
    cap_edge = 2'd0;
    cnt = 16'h0099; cap_in = 1; tick();
    cap_in = 0; tick(); cnt = 16'hFFFF;
    rd(0, v); chk("R5 none", v, 16'h0088);
    cap_edge = 2'd3;
    cnt = 16'h00A1; cap_in = 1; tick();
    cnt = 16'hFFFF; tick();
    rd(0, v); chk("R5 both rise", v, 16'h00A1);
    cnt = 16'h00A2; cap_in = 0; tick();
    cnt = 16'hFFFF;
    rd(0, v); chk("R5 both fall", v, 16'h00A2);

    // R6 capture history
    cap_edge = 2'd1; buf_en = 2'b01;
    cap_pulse(16'h0100);
    rd(0, v); chk("R6 A first", v, 16'h0100);
    rd(2, v); chk("R6 C first", v, 16'h00A2);
    cap_pulse(16'h0200);
    rd(0, v); chk("R6 A second", v, 16'h0200);
    rd(2, v); chk("R6 C second", v, 16'h0100);

    // R8 / R7 compare reload
    mode_cap = 4'b0000;
    wr(2, 16'h0300);
    wr(0, 16'h0999);
    rd(0, v); chk("R8 A write ignored", v, 16'h0200);
    rd(2, v); chk("R8 C write taken", v, 16'h0300);
    cnt = 16'h0200; tick();
    chk("R7 A match", {12'd0, cmp_hit}, 16'h0001);
    cnt = 16'hFFFF;
    rd(0, v); chk("R7 not yet reloaded", v, 16'h0200);
    rd(0, v); chk("R7 reloaded", v, 16'h0300);
    cnt = 16'h0300; tick();
    chk("R7 C no own hit", {12'd0, cmp_hit}, 16'h0001);
    cnt = 16'hFFFF; tick();

    // R9 independent pair enables
    wr(1, 16'h0BBB); wr(3, 16'h0AAA);
    cnt = 16'h0BBB; tick();
    chk("R9 B hit", {12'd0, cmp_hit}, 16'h0002);
    cnt = 16'hFFFF; tick();
    rd(1, v); chk("R9 B no reload unlinked", v, 16'h0BBB);
    cnt = 16'h0AAA; tick();
    chk("R9 D compares unlinked", {12'd0, cmp_hit}, 16'h0008);
    cnt = 16'hFFFF; buf_en = 2'b11;
    cnt = 16'h0BBB; tick();
    cnt = 16'hFFFF; tick();
    rd(1, v); chk("R9 B reloaded from D", v, 16'h0AAA);

    // R10 B/D capture request ignored
    buf_en = 2'b00; mode_cap = 4'b1010; cap_edge = 2'd1;
    cap_pulse(16'h0123);
    rd(1, v); chk("R10 B kept", v, 16'h0AAA);
    rd(3, v); chk("R10 D kept", v, 16'h0AAA);
    cnt = 16'h0AAA; tick();
    chk("R10 B D still compare", {12'd0, cmp_hit}, 16'h000A);
    cnt = 16'hFFFF;

    // R11 capture beats write
    mode_cap = 4'b0001; tick();
    wr_en = 1; wr_sel = 0; wr_data = 16'h1111; cnt = 16'h2222; cap_in = 1;
    tick();
    wr_en = 0; cap_in = 0; cnt = 16'hFFFF; tick();
    rd(0, v); chk("R11 capture wins", v, 16'h2222);

    // random mix checked against model (R2 R3 R4 R6 R7 R9)
    for (int n = 0; n < 6000; n++) begin
      if (n % 150 == 0) begin
        mode_cap = 4'($urandom_range(0, 15));
        buf_en   = 2'($urandom_range(0, 3));
        cap_edge = 2'($urandom_range(0, 3));
      end
      cnt     = 16'($urandom_range(0, 7));
      cap_in  = 1'($urandom_range(0, 1));
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_sel  = 2'($urandom_range(0, 3));
      wr_data = 16'($urandom_range(0, 7));
      rd_sel  = 2'($urandom_range(0, 3));
      tick();
      chk("R2 random read", rd_data, m_rd);
      chk("R3 random hit", {12'd0, cmp_hit}, {12'd0, m_hit});
    end
    wr_en = 0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule